// File: doc/BRIEF.md
# Dual-Controller DMA Programming Register File

This block holds the software-visible programming state of an eight-channel DMA engine. The engine is built as two controllers of four channels each. Software reaches it through an 8-bit I/O port bus with single-cycle reads and writes. Each channel has a 16-bit address register and a 16-bit word count register. Each controller also has a command register, a request register, a status view and a four-bit mask.

Each 16-bit register sits behind a single 8-bit port. A per-controller byte pointer flip-flop picks which half an access reaches and flips after every such access. Three write-only command ports act on the write strobe alone and ignore the data byte: one resets the byte pointer, one performs a master clear, and one unmasks all channels. All stored state is driven out as flat vectors for the transfer engine, which is outside this block.

Controller 0 (channels 0–3) decodes port index `i` at address `i` (00h–0Fh). Controller 1 (channels 4–7) decodes port index `i` at address C0h + 2·i (even addresses C0h–DEh).

Top module: `dma_reg_unit`

## Requirements
- R1: After reset, `mask_o` is FFh, `cmd_o` and `req_o` are zero, and both byte pointers select the low byte.
- R2: Port index 2n reaches the address register of local channel n, and index 2n+1 reaches its count register. For controller 1 this is address C0h+4n and count C2h+4n, for channel 4+n. The first access after the pointer is cleared reaches bits 7:0 and the next reaches bits 15:8. The pointer flips after every read or write of these ports.
- R3: A write to an address or count port updates both the base copy (`base_addr_o`/`base_cnt_o`) and the current copy (`cur_addr_o`/`cur_cnt_o`). Channel n occupies bits [16n+15:16n] of these outputs.
- R4: A write of any data to 0Ch (controller 0) or D8h (controller 1) returns that controller's byte pointer to the low byte.
- R5: A write of any data to 0Dh / D8h+2 (DAh) performs a master clear on that controller. It clears the command, request and byte pointer and sets all four mask bits. Address and count registers are unchanged.
- R6: A write of any data to 0Eh / DCh clears all four mask bits of that controller and changes nothing else.
- R7: A read of 0Bh–0Eh (D6h–DCh), or of an address no controller decodes, returns FFh and changes no state, including the byte pointer. Writes to index 11 are ignored.
- R8: A command aimed at one controller never changes the other controller's state. Controller 0 drives bits 3:0 of `mask_o`/`req_o` and bits 7:0 of `cmd_o`, and controller 1 drives the upper bits.
- R9: A write to index 8 (08h / D0h) loads the 8-bit command register. A read of index 8 returns status: the four request bits in bits 7:4, with bits 3:0 zero.
- R10: Writes to index 9 (request) and index 10 (single mask) use bit 2 as the new bit value and bits 1:0 as the local channel. Index 15 (0Fh / DEh) writes the four mask bits from data bits 3:0 and reads back as {4'hF, mask}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of `io_rd` |
| cmd_o | output | 16 | Command registers, controller 1 in the upper byte |
| mask_o | output | 8 | Channel mask bits, bit n = channel n |
| req_o | output | 8 | Software request bits, bit n = channel n |
| base_addr_o | output | 128 | Base address registers, 16 bits per channel |
| cur_addr_o | output | 128 | Current address registers |
| base_cnt_o | output | 128 | Base word count registers |
| cur_cnt_o | output | 128 | Current word count registers |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle and that each strobe lasts one cycle per bus access. The read side-effect property also relies on there being no concurrent write. The bench drives every access from one task at a time, so each strobe is high for exactly one cycle with an idle cycle after it, and the two strobes never overlap. Byte-pointer sequences are chosen so that a pointer left on the high byte shows up in a later register value.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int DW      = 8;
    localparam int IDXW    = 4;
    localparam int NCTRL   = 2;
    localparam int CH_PER  = 4;

    localparam logic [IDXW-1:0] IDX_CMD    = 4'd8;
    localparam logic [IDXW-1:0] IDX_REQ    = 4'd9;
    localparam logic [IDXW-1:0] IDX_SMASK  = 4'd10;
    localparam logic [IDXW-1:0] IDX_CLRBP  = 4'd12;
    localparam logic [IDXW-1:0] IDX_MCLR   = 4'd13;
    localparam logic [IDXW-1:0] IDX_CLRMSK = 4'd14;
    localparam logic [IDXW-1:0] IDX_AMASK  = 4'd15;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_regs_pkg::*;
#(
    parameter logic [7:0] LO_BASE = 8'h00,
    parameter logic [7:0] HI_BASE = 8'hC0
) (
    input  logic [7:0]       addr,
    output logic [NCTRL-1:0] hit,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        hit = '0;
        idx = '0;
        if (addr[7:4] == LO_BASE[7:4]) begin
            hit[0] = 1'b1;
            idx    = addr[3:0];
        end else if (addr[7:5] == HI_BASE[7:5] && !addr[0]) begin
            hit[1] = 1'b1;
            idx    = addr[4:1];
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regs_pkg::*;
#(
    parameter int CH = CH_PER,
    parameter int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDXW-1:0]   idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     cmd_o,
    output logic [CH-1:0]     req_o,
    output logic [CH-1:0]     mask_o,
    output logic [CH*AW-1:0]  base_addr_o,
    output logic [CH*AW-1:0]  cur_addr_o,
    output logic [CH*AW-1:0]  base_cnt_o,
    output logic [CH*AW-1:0]  cur_cnt_o
);
    localparam int CHW = $clog2(CH);

    typedef struct packed {
        logic                 bptr;
        logic [DW-1:0]        cmd;
        logic [CH-1:0]        req;
        logic [CH-1:0]        mask;
        logic [CH-1:0][AW-1:0] base_addr;
        logic [CH-1:0][AW-1:0] cur_addr;
        logic [CH-1:0][AW-1:0] base_cnt;
        logic [CH-1:0][AW-1:0] cur_cnt;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic           word_acc_d;
    logic [CHW-1:0] ch_sel_d;
    logic           is_cnt_d;
    logic [AW-1:0]  word_rd_d;
    logic [AW-1:0]  word_wr_d;

    always_comb begin
        s_d        = s_q;
        rdata      = '1;
        word_acc_d = (idx < IDXW'(2 * CH));
        ch_sel_d   = idx[CHW:1];
        is_cnt_d   = idx[0];
        word_rd_d  = is_cnt_d ? s_q.cur_cnt[ch_sel_d] : s_q.cur_addr[ch_sel_d];
        word_wr_d  = s_q.bptr ? {wdata, word_rd_d[DW-1:0]} : {word_rd_d[AW-1:DW], wdata};

        if (rd) begin
            if (word_acc_d) begin
                rdata = s_q.bptr ? word_rd_d[AW-1:DW] : word_rd_d[DW-1:0];
            end else if (idx == IDX_CMD) begin
                rdata = {s_q.req, {(DW-CH){1'b0}}};
            end else if (idx == IDX_AMASK) begin
                rdata = {{(DW-CH){1'b1}}, s_q.mask};
            end
        end

        if (wr) begin
            if (word_acc_d) begin
                if (is_cnt_d) begin
                    s_d.base_cnt[ch_sel_d] = word_wr_d;
                    s_d.cur_cnt[ch_sel_d]  = word_wr_d;
                end else begin
                    s_d.base_addr[ch_sel_d] = word_wr_d;
                    s_d.cur_addr[ch_sel_d]  = word_wr_d;
                end
            end else begin
                case (idx)
                    IDX_CMD:    s_d.cmd = wdata;
                    IDX_REQ:    s_d.req[wdata[CHW-1:0]]  = wdata[2];
                    IDX_SMASK:  s_d.mask[wdata[CHW-1:0]] = wdata[2];
                    IDX_AMASK:  s_d.mask = wdata[CH-1:0];
                    IDX_CLRBP:  s_d.bptr = 1'b0;
                    IDX_CLRMSK: s_d.mask = '0;
                    IDX_MCLR: begin
                        s_d.cmd  = '0;
                        s_d.req  = '0;
                        s_d.bptr = 1'b0;
                        s_d.mask = '1;
                    end
                    default: ;
                endcase
            end
        end

        if ((rd || wr) && word_acc_d) begin
            s_d.bptr = ~s_q.bptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o       = s_q.cmd;
    assign req_o       = s_q.req;
    assign mask_o      = s_q.mask;
    assign base_addr_o = s_q.base_addr;
    assign cur_addr_o  = s_q.cur_addr;
    assign base_cnt_o  = s_q.base_cnt;
    assign cur_cnt_o   = s_q.cur_cnt;

    assert_bptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd ^ wr) && idx < IDXW'(2 * CH)) |=> (s_q.bptr != $past(s_q.bptr)));

    assert_clr_bptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_CLRBP) |=> !s_q.bptr);

    assert_master_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_MCLR) |=> (&s_q.mask && s_q.cmd == '0 && s_q.req == '0
                                     && !s_q.bptr && $stable(s_q.base_addr)));

    assert_clear_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_CLRMSK) |=> (s_q.mask == '0 && $stable(s_q.cmd)
                                       && $stable(s_q.req) && $stable(s_q.bptr)));

    assert_cmd_port_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && idx >= IDX_CLRBP - 4'd1 && idx <= IDX_CLRMSK) |=> $stable(s_q));
endmodule

// File: rtl/dma_reg_unit.sv
module dma_reg_unit
    import dma_regs_pkg::*;
#(
    parameter logic [7:0] LO_BASE = 8'h00,
    parameter logic [7:0] HI_BASE = 8'hC0,
    parameter int         AW      = 2 * DW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  io_addr,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [DW-1:0]               io_wdata,
    output logic [DW-1:0]               io_rdata,
    output logic [NCTRL*DW-1:0]         cmd_o,
    output logic [NCTRL*CH_PER-1:0]     mask_o,
    output logic [NCTRL*CH_PER-1:0]     req_o,
    output logic [NCTRL*CH_PER*AW-1:0]  base_addr_o,
    output logic [NCTRL*CH_PER*AW-1:0]  cur_addr_o,
    output logic [NCTRL*CH_PER*AW-1:0]  base_cnt_o,
    output logic [NCTRL*CH_PER*AW-1:0]  cur_cnt_o
);
    localparam int SLICE = CH_PER * AW;

    logic [NCTRL-1:0]         hit;
    logic [IDXW-1:0]          idx;
    logic [NCTRL-1:0][DW-1:0] rd_bus;

    dma_port_decode #(.LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_dec (
        .addr (io_addr),
        .hit  (hit),
        .idx  (idx)
    );

    for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
        dma_ctrl_regs #(.CH(CH_PER), .AW(AW)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr          (io_wr && hit[g]),
            .rd          (io_rd && hit[g]),
            .idx         (idx),
            .wdata       (io_wdata),
            .rdata       (rd_bus[g]),
            .cmd_o       (cmd_o[g*DW +: DW]),
            .req_o       (req_o[g*CH_PER +: CH_PER]),
            .mask_o      (mask_o[g*CH_PER +: CH_PER]),
            .base_addr_o (base_addr_o[g*SLICE +: SLICE]),
            .cur_addr_o  (cur_addr_o[g*SLICE +: SLICE]),
            .base_cnt_o  (base_cnt_o[g*SLICE +: SLICE]),
            .cur_cnt_o   (cur_cnt_o[g*SLICE +: SLICE])
        );
    end

    always_comb begin
        io_rdata = '1;
        for (int k = 0; k < NCTRL; k++) begin
            if (hit[k]) io_rdata = rd_bus[k];
        end
    end

    assert_ctrl_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit[0]) |=> ($stable(cmd_o[2*DW-1:DW]) && $stable(mask_o[2*CH_PER-1:CH_PER])
                               && $stable(req_o[2*CH_PER-1:CH_PER])));
endmodule

// File: tb/dma_reg_unit_tb.sv
module dma_reg_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = '0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic [15:0]  cmd_o;
    logic [7:0]   mask_o;
    logic [7:0]   req_o;
    logic [127:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_reg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cmd_o(cmd_o), .mask_o(mask_o),
        .req_o(req_o), .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o)
    );

    // Monitor: pops expected read bytes while a read strobe is active
    always @(negedge clk) begin
        if (io_rd) begin
            logic [7:0] e;
            string t;
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected read, got %02h", "scoreboard", io_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: read %02h got %02h expected %02h", t, io_addr, io_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] e, input string t);
        tests++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", t, act, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check(mask_o, 8'hFF, "R1 mask");
        check(cmd_o, 16'h0, "R1 cmd");
        check(req_o, 8'h0, "R1 req");

        // R2/R3 channel 1 address via port 02h
        bus_write(8'h02, 8'h34);
        bus_write(8'h02, 8'h12);
        check(base_addr_o[16 +: 16], 16'h1234, "R3 base addr ch1");
        check(cur_addr_o[16 +: 16], 16'h1234, "R3 cur addr ch1");
        bus_read(8'h02, 8'h34, "R2 low byte");
        bus_read(8'h02, 8'h12, "R2 high byte");

        // R2/R3 channel 6 count via CAh
        bus_write(8'hCA, 8'hAB);
        bus_write(8'hCA, 8'hCD);
        check(base_cnt_o[96 +: 16], 16'hCDAB, "R3 base cnt ch6");
        check(cur_cnt_o[96 +: 16], 16'hCDAB, "R3 cur cnt ch6");

        // R4 clear byte pointer after a dangling byte
        bus_write(8'h00, 8'h55);
        bus_write(8'h0C, 8'hA5);
        bus_write(8'h00, 8'h66);
        bus_write(8'h00, 8'h77);
        check(cur_addr_o[0 +: 16], 16'h7766, "R4 ch0 addr");

        // R8 clear pointer on controller 0 leaves controller 1 pointer
        bus_write(8'hC0, 8'h11);
        bus_write(8'h0C, 8'h00);
        bus_write(8'hC0, 8'h22);
        check(cur_addr_o[64 +: 16], 16'h2211, "R8 ch4 addr");

        // R9 command and status, R10 request
        bus_write(8'h08, 8'h5A);
        bus_write(8'hD0, 8'h3C);
        check(cmd_o, 16'h3C5A, "R9 cmd");
        bus_write(8'h09, 8'h06);
        bus_write(8'hD2, 8'h05);
        check(req_o, 8'h24, "R10 req");
        bus_read(8'h08, 8'h40, "R9 status ctrl0");
        bus_read(8'hD0, 8'h20, "R9 status ctrl1");

        // R6 clear mask on controller 0 only
        bus_write(8'h0E, 8'h00);
        check(mask_o, 8'hF0, "R6 mask");
        check(cmd_o, 16'h3C5A, "R6 cmd kept");
        check(req_o, 8'h24, "R6 req kept");

        // R10 single and all mask
        bus_write(8'h0A, 8'h05);
        check(mask_o, 8'hF2, "R10 single mask");
        bus_write(8'hDE, 8'h09);
        check(mask_o, 8'h92, "R10 all mask");
        bus_read(8'h0F, 8'hF2, "R10 mask read ctrl0");
        bus_read(8'hDE, 8'hF9, "R10 mask read ctrl1");

        // R7 command-port reads: FFh, pointer and mask untouched
        bus_write(8'h04, 8'h77);
        bus_read(8'h0B, 8'hFF, "R7 read 0Bh");
        bus_read(8'h0C, 8'hFF, "R7 read 0Ch");
        bus_read(8'h0D, 8'hFF, "R7 read 0Dh");
        bus_read(8'h0E, 8'hFF, "R7 read 0Eh");
        bus_read(8'h50, 8'hFF, "R7 unmapped");
        bus_write(8'h0B, 8'h00);
        bus_write(8'h04, 8'h88);
        check(cur_addr_o[32 +: 16], 16'h8877, "R7 pointer kept");
        check(mask_o, 8'h92, "R7 mask kept");

        // R5 master clear controller 0
        bus_write(8'h06, 8'h01);
        bus_write(8'h0D, 8'hC3);
        check(cmd_o, 16'h3C00, "R5 cmd");
        check(req_o, 8'h20, "R5 req");
        check(mask_o, 8'h9F, "R5 mask");
        check(cur_addr_o[16 +: 16], 16'h1234, "R5 addr kept");
        bus_write(8'h06, 8'h44);
        bus_write(8'h06, 8'h33);
        check(cur_addr_o[48 +: 16], 16'h3344, "R5 pointer cleared");

        // R5/R8 master clear controller 1
        bus_write(8'hDA, 8'h00);
        check(mask_o, 8'hFF, "R5 ctrl1 mask");
        check(cmd_o, 16'h0000, "R5 ctrl1 cmd");
        check(req_o, 8'h00, "R5 ctrl1 req");
        bus_read(8'hCA, 8'hAB, "R2 ch6 count low");
        bus_read(8'hCA, 8'hCD, "R2 ch6 count high");

        @(posedge clk); #1;
        check(exp_q.size(), 0, "scoreboard drained");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule